// File: doc/BRIEF.md
# Terminal-Side Link Activation Controller

This block sequences the terminal end of a basic-rate four-wire subscriber line from idle to fully active and back. It reads two request bits from a control register, one to start activation and one to force deactivation. It also reads three indications from the receiver: frame synchronisation achieved, another terminal active on the bus, and the activation bit carried in received frames. From these it decides which line signal the transmitter should emit: silence, the unlocked wake-up pattern, or full data frames.

The transmit choice is taken once per control frame, on a frame strobe, so a single frame never mixes signal types. The state itself follows the inputs on every clock. The block also drives one shared status bit. It reports the receiver's sync indication while activation is requested and not overridden, and reports bus activity otherwise. A change of the request bits switches that meaning only at the next frame boundary. Line coding, clock recovery, framing and the analog front end sit outside the block; their results arrive as clean synchronous levels.

Top module: `te_link_activator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `link_state` = 0 (Idle), `tx_info` = 2'b00 (silence) and `stat_is_sync` = 0.
- R2: In Idle (state 0), `act_req`=1 with `deact_req`=0 moves `link_state` to 1 (Requesting) on the next clock; otherwise the block stays in Idle.
- R3: In Requesting (state 1), `rx_sync`=1 moves `link_state` to 2 (Synced) on the next clock; otherwise it stays in Requesting.
- R4: In Synced (state 2), `rx_sync`=1 together with `rx_act_bit`=1 moves `link_state` to 3 (Up) on the next clock; any other combination keeps it in Synced.
- R5: In Up (state 3), `rx_sync`=0 moves to Requesting (1). `rx_sync`=1 with `rx_act_bit`=0 moves to Synced (2). Both moves happen on the next clock.
- R6: `deact_req`=1 sends the block to Idle on the next clock from every state, overriding all other inputs.
- R7: `tx_info` changes only on the clock edge at which `frame_strobe` is high; it holds its value on every other cycle.
- R8: At a strobe edge, `tx_info` takes the code chosen from the state held before that edge: Idle gives 2'b00. Requesting gives 2'b01 (wake-up pattern) when `bus_busy`=0 and 2'b00 when `bus_busy`=1. Synced gives 2'b11 (data frames) when `rx_sync`=1 and 2'b00 otherwise. Up gives 2'b11.
- R9: `stat_is_sync`=1 means `stat_bit` equals `rx_sync`; `stat_is_sync`=0 means `stat_bit` equals `bus_busy`. At a strobe edge, `stat_is_sync` loads 1 when `act_req`=1 and `deact_req`=0, and loads 0 otherwise.
- R10: A change of `act_req` or `deact_req` between strobes leaves `stat_is_sync` unchanged until the next strobe edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_strobe | input | 1 | One-cycle pulse marking a control frame boundary |
| act_req | input | 1 | Activation request from the control register |
| deact_req | input | 1 | Deactivation request from the control register |
| rx_sync | input | 1 | Receiver has frame synchronisation |
| bus_busy | input | 1 | Another terminal is signalling on the bus |
| rx_act_bit | input | 1 | Activation bit of the received frame |
| tx_info | output | 2 | Line signal to send: 00 silence, 01 wake-up, 11 data frames |
| link_state | output | 2 | 0 Idle, 1 Requesting, 2 Synced, 3 Up |
| stat_bit | output | 1 | Shared status bit, sync or bus activity |
| stat_is_sync | output | 1 | Current meaning of `stat_bit` (1 = sync) |

## Verification
A wrong state appears on `link_state` one clock after the input that caused it. The bench compares the state on every cycle, so a bad transition is caught at once. A wrong state choice reaches `tx_info` only after the next frame strobe, up to a frame later. A wrong or untimely status-meaning register shows on `stat_is_sync` and `stat_bit` on the cycle after the strobe. It also shows if the register changes between strobes.

// File: rtl/te_link_pkg.sv
// Package: shared encodings for the terminal-side activation controller.
// Assumes: state and transmit codes are both two bits wide.
package te_link_pkg;

    localparam int STATE_W = 2;
    localparam int TXC_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        LS_IDLE = 2'd0,
        LS_REQ  = 2'd1,
        LS_SYNC = 2'd2,
        LS_UP   = 2'd3
    } link_state_t;

    typedef enum logic [TXC_W-1:0] {
        TX_SILENT = 2'b00,
        TX_WAKE   = 2'b01,
        TX_DATA   = 2'b11
    } tx_code_t;

endpackage

// File: rtl/te_act_fsm.sv
// Module: te_act_fsm
// Tracks the four-state activation sequence of the terminal, one step per clock.
// Assumes: all inputs are synchronous to clk; deact_req has top priority.
module te_act_fsm
    import te_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        act_req,
    input  logic        deact_req,
    input  logic        rx_sync,
    input  logic        rx_act_bit,
    output link_state_t state_q
);

    link_state_t state_d;

    // Next-state selection from current state and live indications.
    always_comb begin
        state_d = state_q;
        if (deact_req) begin
            state_d = LS_IDLE;
        end else begin
            unique case (state_q)
                LS_IDLE: if (act_req)                state_d = LS_REQ;
                LS_REQ:  if (rx_sync)                state_d = LS_SYNC;
                LS_SYNC: if (rx_sync && rx_act_bit)  state_d = LS_UP;
                LS_UP: begin
                    if (!rx_sync)                    state_d = LS_REQ;
                    else if (!rx_act_bit)            state_d = LS_SYNC;
                end
                default:                             state_d = LS_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> state_q == LS_IDLE); // R1
    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_IDLE && act_req && !deact_req) |=> state_q == LS_REQ); // R2
    AST_REQ_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_REQ && rx_sync && !deact_req) |=> state_q == LS_SYNC); // R3
    AST_SYNC_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_SYNC && rx_sync && rx_act_bit && !deact_req) |=> state_q == LS_UP); // R4
    AST_UP_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_UP && !rx_sync && !deact_req) |=> state_q == LS_REQ); // R5
    AST_DEACT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        deact_req |=> state_q == LS_IDLE); // R6

endmodule

// File: rtl/te_tx_select.sv
// Module: te_tx_select
// Chooses the line signal once per frame from the activation state.
// Assumes: frame_strobe is a single-cycle pulse; state_q comes from te_act_fsm.
module te_tx_select
    import te_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_strobe,
    input  link_state_t state_q,
    input  logic        rx_sync,
    input  logic        bus_busy,
    output tx_code_t    tx_q
);

    tx_code_t tx_pick;

    // Map the state plus live indications to a transmit code.
    always_comb begin
        unique case (state_q)
            LS_IDLE: tx_pick = TX_SILENT;
            LS_REQ:  tx_pick = bus_busy ? TX_SILENT : TX_WAKE;
            LS_SYNC: tx_pick = rx_sync  ? TX_DATA   : TX_SILENT;
            LS_UP:   tx_pick = TX_DATA;
            default: tx_pick = TX_SILENT;
        endcase
    end

    // Load the chosen code only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)            tx_q <= TX_SILENT;
        else if (frame_strobe) tx_q <= tx_pick;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(tx_q)); // R7
    AST_TX_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && state_q == LS_IDLE) |=> tx_q == TX_SILENT); // R8
    AST_TX_UP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && state_q == LS_UP) |=> tx_q == TX_DATA); // R8

endmodule

// File: rtl/te_status_mux.sv
// Module: te_status_mux
// Holds the per-frame meaning of the shared status bit and drives the bit.
// Assumes: request bits may change at any cycle; meaning follows at the next strobe.
module te_status_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_strobe,
    input  logic act_req,
    input  logic deact_req,
    input  logic rx_sync,
    input  logic bus_busy,
    output logic sel_sync_q,
    output logic stat_bit
);

    // Latch the meaning selector at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)            sel_sync_q <= 1'b0;
        else if (frame_strobe) sel_sync_q <= act_req & ~deact_req;
    end

    // Route sync or bus activity according to the held selector.
    always_comb begin
        stat_bit = sel_sync_q ? rx_sync : bus_busy;
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(sel_sync_q)); // R10
    AST_SEL_DEACT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && deact_req) |=> !sel_sync_q); // R9
    AST_SEL_RESET: assert property (@(posedge clk) !rst_n |=> !sel_sync_q); // R1

endmodule

// File: rtl/te_link_activator.sv
// Module: te_link_activator (top)
// Terminal-side activation controller: state sequence, per-frame transmit choice
// and shared status bit. Assumes synchronous, glitch-free receiver indications.
module te_link_activator
    import te_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_strobe,
    input  logic               act_req,
    input  logic               deact_req,
    input  logic               rx_sync,
    input  logic               bus_busy,
    input  logic               rx_act_bit,
    output logic [TXC_W-1:0]   tx_info,
    output logic [STATE_W-1:0] link_state,
    output logic               stat_bit,
    output logic               stat_is_sync
);

    link_state_t state_w;
    tx_code_t    tx_w;

    te_act_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_req    (act_req),
        .deact_req  (deact_req),
        .rx_sync    (rx_sync),
        .rx_act_bit (rx_act_bit),
        .state_q    (state_w)
    );

    te_tx_select u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .state_q      (state_w),
        .rx_sync      (rx_sync),
        .bus_busy     (bus_busy),
        .tx_q         (tx_w)
    );

    te_status_mux u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .act_req      (act_req),
        .deact_req    (deact_req),
        .rx_sync      (rx_sync),
        .bus_busy     (bus_busy),
        .sel_sync_q   (stat_is_sync),
        .stat_bit     (stat_bit)
    );

    // Present internal enums as plain vectors at the boundary.
    always_comb begin
        tx_info    = tx_w;
        link_state = state_w;
    end

endmodule

// File: tb/te_link_activator_bench.sv
module te_link_activator_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_strobe = 1'b0;
    logic act_req = 1'b0;
    logic deact_req = 1'b0;
    logic rx_sync = 1'b0;
    logic bus_busy = 1'b0;
    logic rx_act_bit = 1'b0;
    logic [1:0] tx_info;
    logic [1:0] link_state;
    logic stat_bit;
    logic stat_is_sync;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference
    int m_state = 0;
    int m_tx = 0;
    int m_sel = 0;

    always #2 clk = ~clk;  // 250 MHz

    te_link_activator u_te_link_activator (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .act_req(act_req), .deact_req(deact_req), .rx_sync(rx_sync),
        .bus_busy(bus_busy), .rx_act_bit(rx_act_bit), .tx_info(tx_info),
        .link_state(link_state), .stat_bit(stat_bit), .stat_is_sync(stat_is_sync)
    );

    // Reference model update on each rising edge (inputs are stable then).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_tx = 0; m_sel = 0;
        end else begin
            if (frame_strobe) begin
                if (m_state == 0)      m_tx = 0;
                else if (m_state == 1) m_tx = bus_busy ? 0 : 1;
                else if (m_state == 2) m_tx = rx_sync ? 3 : 0;
                else                   m_tx = 3;
                m_sel = (act_req && !deact_req) ? 1 : 0;
            end
            if (deact_req)                        m_state = 0;
            else if (m_state == 0 && act_req)     m_state = 1;
            else if (m_state == 1 && rx_sync)     m_state = 2;
            else if (m_state == 2 && rx_sync && rx_act_bit) m_state = 3;
            else if (m_state == 3 && !rx_sync)    m_state = 1;
            else if (m_state == 3 && !rx_act_bit) m_state = 2;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2/R3/R4/R5/R6", "link_state", int'(link_state), m_state);
        check("R7/R8", "tx_info", int'(tx_info), m_tx);
        check("R9/R10", "stat_is_sync", int'(stat_is_sync), m_sel);
        check("R9", "stat_bit", int'(stat_bit), m_sel ? int'(rx_sync) : int'(bus_busy));
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic step(input bit strb);
        @(negedge clk);
        compare_all();
        frame_strobe = strb;
    endtask

    task automatic frames(input int n);
        for (int f = 0; f < n; f++) begin
            step(1'b1);
            for (int c = 0; c < 3; c++) step(1'b0);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "link_state", int'(link_state), 0);
        check("R1", "tx_info", int'(tx_info), 0);
        check("R1", "stat_is_sync", int'(stat_is_sync), 0);
        rst_n = 1'b1;
        frames(2);
        // R2, R8: request while bus busy -> silence, then wake-up
        act_req = 1'b1; bus_busy = 1'b1;
        frames(2);
        check("R2", "state requesting", int'(link_state), 1);
        check("R8", "busy silence", int'(tx_info), 0);
        bus_busy = 1'b0;
        frames(2);
        check("R8", "wake-up", int'(tx_info), 1);
        // R3: sync acquired
        rx_sync = 1'b1;
        frames(2);
        check("R3", "state synced", int'(link_state), 2);
        check("R8", "data frames", int'(tx_info), 3);
        rx_sync = 1'b0; frames(2);
        check("R8", "synced no sync silence", int'(tx_info), 0);
        rx_sync = 1'b1; rx_act_bit = 1'b1;
        frames(2);
        check("R4", "state up", int'(link_state), 3);
        rx_act_bit = 1'b0; frames(1);
        check("R5", "up lost A", int'(link_state), 2);
        rx_act_bit = 1'b1; frames(1);
        rx_sync = 1'b0; frames(1);
        check("R5", "up lost sync", int'(link_state), 1);
        // R10: drop request mid-frame, meaning stays until strobe
        rx_sync = 1'b1; rx_act_bit = 1'b1; frames(2);
        step(1'b0);
        act_req = 1'b0;
        step(1'b0);
        check("R10", "meaning held mid-frame", int'(stat_is_sync), 1);
        step(1'b1); step(1'b0);
        check("R10", "meaning after strobe", int'(stat_is_sync), 0);
        // R6: deactivation from Up
        act_req = 1'b1; frames(2);
        deact_req = 1'b1; step(1'b0); step(1'b0);
        check("R6", "deactivated", int'(link_state), 0);
        deact_req = 1'b0;
        frames(2);
        // mixed stimulus
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare_all();
            frame_strobe = (i % 8) == 0;
            act_req    = ($urandom % 8) != 0;
            deact_req  = ($urandom % 16) == 0;
            rx_sync    = ($urandom % 4) != 0;
            bus_busy   = ($urandom % 3) == 0;
            rx_act_bit = ($urandom % 4) != 0;
        end
        @(negedge clk);
        compare_all();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule